// File: doc/BRIEF.md
# Programmable Pseudo-Random and Repetitive Bit Pattern Generator

This block produces one test pattern bit per enabled clock from a 32-bit shift register. The register shifts from bit 1 (the LSB) toward bit 32 (the MSB), and each new bit enters at bit 1. The bit that enters is also the output bit, with one exception: in QRSS mode a long zero run forces the output to one.

Three pattern kinds are available:
- A pseudo-random sequence whose feedback is the XOR of two register bits chosen at run time.
- A QRSS sequence that uses fixed taps and suppresses long runs of zeros.
- A repetitive pattern, in which the bit at the programmed length position is fed back so that a loaded word recirculates.

Software sets the tap positions, the pattern kind and a 32-bit seed. These settings take effect only when the load control rises from zero to one. From then on, the bit-enable paces the output.

Top module: `pattern_gen`

## Requirements
- R1: While reset is active and after it is released, the register holds all zeros and the stored settings are pseudo-random mode, QRSS off and both tap codes 0. Because of R6, `bit_o` reads 1 in this state.
- R2: In pseudo-random mode (`rep_mode_i`=0, `qrss_en_i`=0), the feedback is register bit n XOR register bit y. A tap code k on `tap_n_i` or `tap_y_i` selects register bit k+1, so code 0 is bit 1 and code 31 is bit 32.
- R3: In repetitive mode (`rep_mode_i`=1), the feedback is register bit n, so the lowest n bits of the loaded seed repeat with period n. The QRSS enable and the y tap have no effect in this mode.
- R4: With `rep_mode_i`=0 and `qrss_en_i`=1, the feedback is register bit 17 XOR register bit 20, and both tap codes are ignored.
- R5: In QRSS mode, `bit_o` is forced to 1 whenever register bits 1 through 14 are all zero. The register still takes the unforced feedback.
- R6: In pseudo-random and QRSS modes, the feedback is forced to 1 when register bits 1 through 31 are all zero. In repetitive mode it is never forced, so an all-zero word stays zero.
- R7: Mode, QRSS enable, taps and seed are captured only on a clock at which `load_i` is 1 and was 0 at the previous clock. Holding `load_i` high, or changing the settings without a new rising edge, has no effect.
- R8: On a load event the seed is copied into the register, whatever the bit-enable is, and no shift happens in that cycle. Shifting resumes at the next enabled clock.
- R9: On a clock with `bit_en_i`=0 and no load event, the register, and with it `bit_o`, keeps its value.
- R10: Each enabled clock without a load event shifts the register up by one place, with the feedback entering bit 1. The output sequence is therefore the successive feedback values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Advance the pattern by one bit |
| tap_n_i | input | 5 | Tap n code (register bit = code+1); pattern length in repetitive mode |
| tap_y_i | input | 5 | Tap y code (register bit = code+1) |
| rep_mode_i | input | 1 | 1 = repetitive pattern, 0 = pseudo-random |
| qrss_en_i | input | 1 | QRSS mode when not repetitive |
| seed_i | input | 32 | Word copied into the register on a load event |
| load_i | input | 1 | A rising edge captures the settings and the seed |
| bit_o | output | 1 | Current pattern bit |

## Verification
The bench exercises each mode with its own seeds:
- Pseudo-random mode is driven with short, medium and long tap pairs, which separates a wrong tap index from a wrong shift direction.
- QRSS mode is loaded once with a full seed and once with a seed whose bits 1 to 14 are zero. The second case separates output forcing from feedback forcing.
- Repetitive mode is tried with all ones, all zeros, alternating, 1-in-4, 1-in-8, 3-in-24 and a full 32-bit word. The all-zeros case shows that lock-up protection stays out of this mode.

Directed sequences cover the remaining cases: a load held high while the settings change, a load in the same cycle as the enable, stalls, and the same seed run through pseudo-random and QRSS taps.

// File: rtl/pattern_gen_pkg.sv
package pattern_gen_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned TAP_W = $clog2(REG_W);

  typedef enum logic {
    MODE_PRBS = 1'b0,
    MODE_REP  = 1'b1
  } mode_e;

  typedef struct packed {
    mode_e            mode;
    logic             qrss;
    logic [TAP_W-1:0] tap_n;
    logic [TAP_W-1:0] tap_y;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode: MODE_PRBS, qrss: 1'b0, tap_n: '0, tap_y: '0};
endpackage

// File: rtl/load_edge_det.sv
module load_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic evt_o
);
  logic load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= load_i;
  end

  assign evt_o = load_i & ~load_q;

  // R7
  no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/pattern_cfg_reg.sv
module pattern_cfg_reg
  import pattern_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= CFG_RESET;
    else if (evt_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cfg_o));

  // R7
  cfg_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> cfg_o == $past(cfg_i));
endmodule

// File: rtl/pattern_feedback.sv
module pattern_feedback
  import pattern_gen_pkg::*;
#(
  parameter int unsigned W        = REG_W,
  parameter int unsigned QRSS_A   = 17,
  parameter int unsigned QRSS_B   = 20,
  parameter int unsigned ZERO_RUN = 14
) (
  input  logic [W-1:0] state_i,
  input  cfg_t         cfg_i,
  output logic         fb_o,
  output logic         bit_o
);
  logic tap_n_bit, tap_y_bit, raw_fb, lock_zero, run_zero, is_rep;

  assign tap_n_bit = state_i[cfg_i.tap_n];
  assign tap_y_bit = state_i[cfg_i.tap_y];
  assign is_rep    = (cfg_i.mode == MODE_REP);
  // bits 1..W-1 all zero
  assign lock_zero = ~|state_i[W-2:0];
  assign run_zero  = ~|state_i[ZERO_RUN-1:0];

  always_comb begin
    if (cfg_i.qrss) raw_fb = state_i[QRSS_A-1] ^ state_i[QRSS_B-1];
    else            raw_fb = tap_n_bit ^ tap_y_bit;

    if (is_rep) fb_o = tap_n_bit;
    else        fb_o = raw_fb | lock_zero;
  end

  assign bit_o = fb_o | (!is_rep && cfg_i.qrss && run_zero);
endmodule

// File: rtl/pattern_shift.sv
module pattern_shift #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         en_i,
  input  logic [W-1:0] seed_i,
  input  logic         fb_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (evt_i) state_q <= seed_i;
    else if (en_i)  state_q <= {state_q[W-2:0], fb_i};
  end

  assign state_o = state_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !evt_i) |=> $stable(state_o));

  // R8
  load_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> state_o == $past(seed_i));

  // R10
  shift_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !evt_i) |=> state_o[W-1:1] == $past(state_o[W-2:0]));
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen
  import pattern_gen_pkg::*;
#(
  parameter int unsigned QRSS_A   = 17,
  parameter int unsigned QRSS_B   = 20,
  parameter int unsigned ZERO_RUN = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic [TAP_W-1:0] tap_n_i,
  input  logic [TAP_W-1:0] tap_y_i,
  input  logic             rep_mode_i,
  input  logic             qrss_en_i,
  input  logic [REG_W-1:0] seed_i,
  input  logic             load_i,
  output logic             bit_o
);
  logic             load_evt, fb;
  logic [REG_W-1:0] state;
  cfg_t             cfg_in, cfg;

  assign cfg_in = '{mode: mode_e'(rep_mode_i), qrss: qrss_en_i, tap_n: tap_n_i, tap_y: tap_y_i};

  load_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .evt_o (load_evt)
  );

  pattern_cfg_reg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (load_evt),
    .cfg_i (cfg_in),
    .cfg_o (cfg)
  );

  pattern_shift #(.W(REG_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (load_evt),
    .en_i   (bit_en_i),
    .seed_i (seed_i),
    .fb_i   (fb),
    .state_o(state)
  );

  pattern_feedback #(
    .W(REG_W), .QRSS_A(QRSS_A), .QRSS_B(QRSS_B), .ZERO_RUN(ZERO_RUN)
  ) u_fb (
    .state_i(state),
    .cfg_i  (cfg),
    .fb_o   (fb),
    .bit_o  (bit_o)
  );

  // R6
  lockup_escape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == MODE_PRBS && state[REG_W-2:0] == '0 && bit_en_i && !load_evt)
      |=> state[0]);

  // R5
  zero_run_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == MODE_PRBS && cfg.qrss && state[ZERO_RUN-1:0] == '0) |-> bit_o);

  // R6
  rep_zero_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.mode == MODE_REP && state == '0 && !load_evt) |=> state == '0);

  // R10
  out_enters_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !load_evt && !(cfg.qrss && cfg.mode == MODE_PRBS)) |=> state[0] == $past(bit_o));
endmodule

// File: tb/pattern_gen_bench.sv
`timescale 1ns/1ps
module pattern_gen_bench;
  localparam int unsigned W   = 32;
  localparam int unsigned TW  = 5;
  localparam realtime     CLK = 8.0;
  localparam int unsigned NV  = 11;
  localparam int unsigned RUN = 48;

  // {rep, qrss, n_code, y_code, seed}
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd8,  5'd4,  32'h0000_01FF},
    {1'b0, 1'b0, 5'd14, 5'd13, 32'h0000_7FFF},
    {1'b0, 1'b0, 5'd22, 5'd17, 32'h007F_FFFF},
    {1'b0, 1'b1, 5'd0,  5'd0,  32'h000F_FFFF},
    {1'b0, 1'b1, 5'd5,  5'd9,  32'h0000_4000},
    {1'b0, 1'b0, 5'd30, 5'd27, 32'h0000_0000},
    {1'b1, 1'b0, 5'd0,  5'd0,  32'h0000_0001},
    {1'b1, 1'b0, 5'd0,  5'd0,  32'h0000_0000},
    {1'b1, 1'b0, 5'd7,  5'd0,  32'h0000_0001},
    {1'b1, 1'b0, 5'd23, 5'd0,  32'h0010_0202},
    {1'b1, 1'b1, 5'd31, 5'd3,  32'hDEAD_BEEF}
  };

  logic          clk_i = 1'b0, rst_ni = 1'b0, bit_en_i = 1'b0;
  logic [TW-1:0] tap_n_i = '0, tap_y_i = '0;
  logic          rep_mode_i = 1'b0, qrss_en_i = 1'b0, load_i = 1'b0;
  logic [W-1:0]  seed_i = '0;
  logic          bit_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0]  m_reg = '0;
  logic          m_rep = 1'b0, m_qrss = 1'b0, m_ld_q = 1'b0;
  logic [TW-1:0] m_n = '0, m_y = '0;

  pattern_gen u_pattern_gen (
    .clk_i, .rst_ni, .bit_en_i, .tap_n_i, .tap_y_i, .rep_mode_i,
    .qrss_en_i, .seed_i, .load_i, .bit_o
  );

  always #(CLK/2) clk_i = ~clk_i;

  function automatic logic m_fb();
    if (m_rep) return m_reg[m_n];
    if (m_reg[W-2:0] == '0) return 1'b1;
    if (m_qrss) return m_reg[16] ^ m_reg[19];
    return m_reg[m_n] ^ m_reg[m_y];
  endfunction

  function automatic logic m_out();
    return m_fb() | (!m_rep && m_qrss && m_reg[13:0] == '0);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: bit_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // called just after a negedge; drives, crosses one posedge, returns after next negedge
  task automatic tick(input logic en, input logic ld);
    logic f;
    bit_en_i = en;
    load_i   = ld;
    @(posedge clk_i);
    f = m_fb();
    if (ld && !m_ld_q) begin
      m_reg = seed_i; m_rep = rep_mode_i; m_qrss = qrss_en_i;
      m_n = tap_n_i;  m_y = tap_y_i;
    end else if (en) begin
      m_reg = {m_reg[W-2:0], f};
    end
    m_ld_q = ld;
    @(negedge clk_i);
  endtask

  task automatic setup(input logic rep, input logic q, input logic [TW-1:0] n,
                       input logic [TW-1:0] y, input logic [W-1:0] s);
    rep_mode_i = rep; qrss_en_i = q; tap_n_i = n; tap_y_i = y; seed_i = s;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic prev;
    string tag;
    @(negedge clk_i);
    @(negedge clk_i);
    // R1 during reset
    check("R1", bit_o, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", bit_o, 1'b1);
    // R1 after reset: settings from reset, default prbs with codes 0 -> lock-up gives ones
    tick(1'b1, 1'b0);
    check("R1", bit_o, 1'b0);   // reg=1: bit1^bit1=0
    tick(1'b1, 1'b0);
    check("R1", bit_o, 1'b0);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][43], VEC[v][42], VEC[v][41:37], VEC[v][36:32], VEC[v][31:0]);
      if (VEC[v][43])      tag = "R3";
      else if (VEC[v][42]) tag = "R4";
      else if (VEC[v][31:0] == '0) tag = "R6";
      else                 tag = "R2";
      for (int k = 0; k < RUN; k++) begin
        check(tag, bit_o, m_out());
        tick(1'b1, 1'b0);
      end
    end

    // R6 repetitive all zeros stays zero
    setup(1'b1, 1'b0, 5'd0, 5'd0, 32'h0);
    for (int k = 0; k < 6; k++) begin
      check("R6", bit_o, 1'b0);
      tick(1'b1, 1'b0);
    end

    // R3 alternating: 0,1,0,1
    setup(1'b1, 1'b0, 5'd1, 5'd0, 32'h1);
    for (int k = 0; k < 6; k++) begin
      check("R3", bit_o, logic'(k % 2));
      tick(1'b1, 1'b0);
    end

    // R7: hold load high, change settings, no effect
    tick(1'b1, 1'b1);   // rising edge here reloads same alternating config
    rep_mode_i = 1'b0; tap_n_i = 5'd0; seed_i = 32'h0;
    for (int k = 0; k < 6; k++) begin
      check("R7", bit_o, logic'(k % 2));
      tick(1'b1, 1'b1);
    end
    // new rising edge does take the new settings: prbs, codes 0/0, seed 0 -> lock-up 1
    tap_y_i = 5'd0;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    check("R7", bit_o, 1'b1);
    check("R7", bit_o, m_out());

    // R8: load with enable high, seed not shifted; 1-in-4 gives 0,0,0,1,0,0,0,1
    rep_mode_i = 1'b1; qrss_en_i = 1'b0; tap_n_i = 5'd3; seed_i = 32'h1;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      check("R8", bit_o, logic'(k % 4 == 3));
      tick(1'b1, 1'b0);
    end

    // R9: stall keeps output
    setup(1'b0, 1'b0, 5'd8, 5'd4, 32'h0000_0155);
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
    prev = bit_o;
    for (int k = 0; k < 5; k++) begin
      tick(1'b0, 1'b0);
      check("R9", bit_o, prev);
    end
    for (int k = 0; k < 10; k++) begin
      check("R9", bit_o, m_out());
      tick(1'b1, 1'b0);
    end

    // R5: QRSS forces output while raw feedback is zero; PRBS on 17/20 does not
    setup(1'b0, 1'b1, 5'd0, 5'd0, 32'h0000_4000);
    check("R5", bit_o, 1'b1);
    tick(1'b1, 1'b0);
    check("R5", bit_o, 1'b1);
    setup(1'b0, 1'b0, 5'd16, 5'd19, 32'h0000_4000);
    check("R4", bit_o, 1'b0);

    // R10: shift direction, rep n=32 seed with bit32 set first
    setup(1'b1, 1'b0, 5'd31, 5'd0, 32'hC000_0000);
    check("R10", bit_o, 1'b1);
    tick(1'b1, 1'b0);
    check("R10", bit_o, 1'b1);
    tick(1'b1, 1'b0);
    check("R10", bit_o, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule